// File: doc/BRIEF.md
# Averaged Temperature Result Formatter

This block sits behind a temperature converter and turns its stream of raw readings into a published temperature word. Each reading arrives as a signed two's-complement number in units of 0.125 °C together with a one-cycle valid strobe. The block sums a fixed window of 16 consecutive valid readings and divides the sum by 16 with an arithmetic shift. It then clamps the average to the range −128 °C to +128 °C and adds a mid-scale offset. The result is a 12-bit offset-binary word in which 0x800 stands for 0 °C, 0x400 for −128 °C and 0xC00 for +128 °C.

Each new result is compared against two programmable limit words held in the same offset-binary code. The comparison drives an over-temperature flag and an under-temperature flag, which a downstream sequencing controller uses to react to thermal events. The result word, both flags and a one-cycle update pulse all change together on the clock edge that takes in the last reading of a window. Between those edges they hold.

Top module: `temp_avg_fmt`

## Requirements
- R1: A synchronous reset drives the result to 0x800, holds the update pulse and both flags low, and empties the accumulator and the reading counter.
- R2: Each published result equals floor(S/16) + 0x800, where S is the signed sum of 16 valid readings. The floor rounds toward negative infinity, so a sum of −120 gives 0x7F8.
- R3: Only cycles with the valid strobe high contribute a reading. Data on cycles with the strobe low is ignored, and idle cycles may fall anywhere inside a window.
- R4: The update pulse is high for exactly one cycle, in the cycle that follows the clock edge taking in the 16th valid reading. The result word changes only in that cycle.
- R5: An average above +128 °C publishes 0xC00.
- R6: An average below −128 °C publishes 0x400.
- R7: The over-temperature flag is 1 when the new result is strictly greater than the high limit. It is 0 when the result equals the high limit.
- R8: The under-temperature flag is 1 when the new result is strictly less than the low limit. It is 0 when the result equals the low limit.
- R9: Both flags change only together with the update pulse. A change of either limit between results does not affect the flags until the next result is published.
- R10: A reset in the middle of a window throws away the partial sum. The next result is built only from readings taken after the reset.
- R11: A steady reading of +25.5 °C (204) publishes 0x8CC, and a steady reading of −25 °C (−200) publishes 0x738.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Reading strobe, one reading per high cycle |
| sampleData | input | SAMPLE_W | Signed reading in 0.125 °C units |
| hiLimit | input | RES_W | Over-temperature limit, offset binary |
| loLimit | input | RES_W | Under-temperature limit, offset binary |
| result | output | RES_W | Published average, offset binary |
| resultUpd | output | 1 | One-cycle pulse when a new result is published |
| overTemp | output | 1 | Result above the high limit |
| underTemp | output | 1 | Result below the low limit |

## Verification
The bench builds the block with its default values: 14-bit readings, a 16-reading window and a 12-bit result. With 14-bit readings, averages far beyond ±128 °C can be driven, so both clamps can be reached, and each limit can be placed exactly on the result to test that the comparisons are strict. Ramps with odd steps put the average at half-LSB points, so the bench can tell flooring apart from rounding. Idle cycles carry junk data inside every window, and a reset in the middle of a window shows whether a partial sum leaks into the next result.

// File: rtl/tavg_pkg.sv
package tavg_pkg;

  // Strobes passed from the sequencing control to the datapath
  typedef struct packed {
    logic addSample;  // fold the current reading into the sum
    logic publish;    // this reading closes the window
  } tavgStrobe_t;

endpackage

// File: rtl/tavg_ctrl.sv
module tavg_ctrl
  import tavg_pkg::*;
#(
  parameter int AVG_LOG2 = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sampleValid,
  output tavgStrobe_t strobe
);

  localparam int CNT_W = AVG_LOG2;

  logic [CNT_W-1:0] sampleCnt;
  logic             lastSample;

  assign lastSample = (sampleCnt == {CNT_W{1'b1}});

  always_comb begin
    strobe.addSample = sampleValid;
    strobe.publish   = sampleValid && lastSample;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleCnt <= '0;
    end else if (sampleValid) begin
      sampleCnt <= sampleCnt + 1'b1;
    end
  end

  // R3: idle cycles leave the window position untouched
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> $stable(sampleCnt));

  // R4: a window close is followed by a fresh window start
  a_r4_window_restart: assert property (@(posedge clk) disable iff (rst)
    strobe.publish |=> (sampleCnt == '0));

endmodule

// File: rtl/tavg_datapath.sv
module tavg_datapath
  import tavg_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int AVG_LOG2 = 4,
  parameter int RES_W    = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  tavgStrobe_t         strobe,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [RES_W-1:0]    hiLimit,
  input  logic [RES_W-1:0]    loLimit,
  output logic [RES_W-1:0]    result,
  output logic                resultUpd,
  output logic                overTemp,
  output logic                underTemp
);

  localparam int SUM_W     = SAMPLE_W + AVG_LOG2;
  localparam int OFFSET    = 1 << (RES_W - 1);
  localparam int HALF_SPAN = 1 << (RES_W - 2);
  localparam logic signed [SUM_W-1:0] TOP_VAL = SUM_W'(HALF_SPAN);
  localparam logic signed [SUM_W-1:0] BOT_VAL = -SUM_W'(HALF_SPAN);
  localparam logic [RES_W-1:0] MID_CODE = RES_W'(OFFSET);
  localparam logic [RES_W-1:0] LO_CODE  = RES_W'(OFFSET - HALF_SPAN);
  localparam logic [RES_W-1:0] HI_CODE  = RES_W'(OFFSET + HALF_SPAN);

  logic signed [SUM_W-1:0] accReg;
  logic signed [SUM_W-1:0] sampleExt;
  logic signed [SUM_W-1:0] sumNext;
  logic signed [SUM_W-1:0] avgVal;
  logic signed [SUM_W-1:0] satVal;
  logic        [SUM_W-1:0] biased;
  logic        [RES_W-1:0] resNext;

  assign sampleExt = signed'({{AVG_LOG2{sampleData[SAMPLE_W-1]}}, sampleData});
  assign sumNext   = accReg + sampleExt;
  assign avgVal    = sumNext >>> AVG_LOG2;

  always_comb begin
    if (avgVal > TOP_VAL) begin
      satVal = TOP_VAL;
    end else if (avgVal < BOT_VAL) begin
      satVal = BOT_VAL;
    end else begin
      satVal = avgVal;
    end
    biased  = satVal + SUM_W'(OFFSET);
    resNext = biased[RES_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accReg    <= '0;
      result    <= MID_CODE;
      resultUpd <= 1'b0;
      overTemp  <= 1'b0;
      underTemp <= 1'b0;
    end else begin
      resultUpd <= strobe.publish;
      if (strobe.publish) begin
        accReg    <= '0;
        result    <= resNext;
        overTemp  <= (resNext > hiLimit);
        underTemp <= (resNext < loLimit);
      end else if (strobe.addSample) begin
        accReg <= sumNext;
      end
    end
  end

  // R4: the published word moves only with the update pulse
  a_r4_result_hold: assert property (@(posedge clk) disable iff (rst)
    !resultUpd |-> $stable(result));

  // R4: the update pulse never lasts two cycles
  a_r4_pulse_single: assert property (@(posedge clk) disable iff (rst)
    resultUpd |=> !resultUpd);

  // R5 and R6: the published word stays inside the clamp range
  a_r5_r6_range: assert property (@(posedge clk) disable iff (rst)
    (result >= LO_CODE) && (result <= HI_CODE));

  // R9: the flags are frozen between results
  a_r9_flag_hold: assert property (@(posedge clk) disable iff (rst)
    !resultUpd |-> ($stable(overTemp) && $stable(underTemp)));

  // R7: the over flag matches the limit seen at publish time
  a_r7_over_cmp: assert property (@(posedge clk) disable iff (rst)
    resultUpd |-> (overTemp == (result > $past(hiLimit))));

  // R8: the under flag matches the limit seen at publish time
  a_r8_under_cmp: assert property (@(posedge clk) disable iff (rst)
    resultUpd |-> (underTemp == (result < $past(loLimit))));

endmodule

// File: rtl/temp_avg_fmt.sv
module temp_avg_fmt
  import tavg_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int AVG_LOG2 = 4,
  parameter int RES_W    = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [RES_W-1:0]    hiLimit,
  input  logic [RES_W-1:0]    loLimit,
  output logic [RES_W-1:0]    result,
  output logic                resultUpd,
  output logic                overTemp,
  output logic                underTemp
);

  tavgStrobe_t strobe;

  tavg_ctrl #(
    .AVG_LOG2 (AVG_LOG2)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sampleValid (sampleValid),
    .strobe      (strobe)
  );

  tavg_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .AVG_LOG2 (AVG_LOG2),
    .RES_W    (RES_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .sampleData (sampleData),
    .hiLimit    (hiLimit),
    .loLimit    (loLimit),
    .result     (result),
    .resultUpd  (resultUpd),
    .overTemp   (overTemp),
    .underTemp  (underTemp)
  );

endmodule

// File: tb/temp_avg_fmt_test.sv
module temp_avg_fmt_test;

  localparam int SAMPLE_W = 14;
  localparam int RES_W    = 12;
  localparam int WIN      = 16;

  typedef struct packed {
    logic [31:0]      base;
    logic [31:0]      step;
    logic [RES_W-1:0] hi;
    logic [RES_W-1:0] lo;
    logic [RES_W-1:0] expRes;
    logic             expOv;
    logic             expUn;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'sd204,   32'sd0,  12'h900, 12'h700, 12'h8CC, 1'b0, 1'b0},
    '{-32'sd200,  32'sd0,  12'h800, 12'h740, 12'h738, 1'b0, 1'b1},
    '{32'sd0,     32'sd1,  12'h806, 12'h807, 12'h807, 1'b1, 1'b0},
    '{32'sd0,    -32'sd1,  12'h7F8, 12'h7F9, 12'h7F8, 1'b0, 1'b1},
    '{32'sd1100,  32'sd0,  12'hBFF, 12'h000, 12'hC00, 1'b1, 1'b0},
    '{-32'sd1500, 32'sd0,  12'hFFF, 12'h401, 12'h400, 1'b0, 1'b1},
    '{32'sd1024,  32'sd0,  12'hC00, 12'h400, 12'hC00, 1'b0, 1'b0},
    '{-32'sd1024, 32'sd0,  12'h3FF, 12'h400, 12'h400, 1'b1, 1'b0}
  };

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                sampleValid = 1'b0;
  logic [SAMPLE_W-1:0] sampleData = '0;
  logic [RES_W-1:0]    hiLimit = 12'hFFF;
  logic [RES_W-1:0]    loLimit = 12'h000;
  logic [RES_W-1:0]    result;
  logic                resultUpd;
  logic                overTemp;
  logic                underTemp;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  temp_avg_fmt uut (
    .clk         (clk),
    .rst         (rst),
    .sampleValid (sampleValid),
    .sampleData  (sampleData),
    .hiLimit     (hiLimit),
    .loLimit     (loLimit),
    .result      (result),
    .resultUpd   (resultUpd),
    .overTemp    (overTemp),
    .underTemp   (underTemp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one valid reading per call; early counts pulses seen before the window closes
  task automatic push(input logic [SAMPLE_W-1:0] v, inout int early);
    @(negedge clk);
    if (resultUpd) early++;
    sampleValid = 1'b1;
    sampleData  = v;
  endtask

  task automatic idle();
    @(negedge clk);
    sampleValid = 1'b0;
    sampleData  = 14'h1FFF;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int early;
    repeat (3) @(negedge clk);
    chk("R1 reset result", 32'(result), 32'h800);
    chk("R1 reset pulse", 32'(resultUpd), 0);
    chk("R1 reset flags", 32'({overTemp, underTemp}), 0);
    rst = 1'b0;

    // table walk: ramps and steady levels with junk idle cycles inside each window
    for (int k = 0; k < NVEC; k++) begin
      hiLimit = VECS[k].hi;
      loLimit = VECS[k].lo;
      early = 0;
      for (int i = 0; i < WIN; i++) begin
        push(SAMPLE_W'(int'(VECS[k].base) + i * int'(VECS[k].step)), early);
        if (i % 2 == 1 && i != WIN - 1) idle();
      end
      @(negedge clk);
      sampleValid = 1'b0;
      chk("R4 no early pulse", 32'(early), 0);
      chk("R4 pulse on window close", 32'(resultUpd), 1);
      chk("R2 R3 R5 R6 R11 result", 32'(result), 32'(VECS[k].expRes));
      chk("R7 over flag", 32'(overTemp), 32'(VECS[k].expOv));
      chk("R8 under flag", 32'(underTemp), 32'(VECS[k].expUn));
      @(negedge clk);
      chk("R4 pulse single cycle", 32'(resultUpd), 0);
    end

    // R9: moving limits between results does not move the flags
    hiLimit = 12'hFFF;
    loLimit = 12'h000;
    repeat (4) idle();
    chk("R9 over held", 32'(overTemp), 1);
    chk("R9 under held", 32'(underTemp), 0);
    chk("R4 result held", 32'(result), 32'h400);

    // R10: partial window thrown away by reset
    early = 0;
    for (int i = 0; i < 5; i++) push(14'sd800, early);
    @(negedge clk);
    sampleValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 mid reset result", 32'(result), 32'h800);
    chk("R1 mid reset flags", 32'({overTemp, underTemp}), 0);
    rst = 1'b0;
    hiLimit = 12'h800;
    loLimit = 12'h808;
    for (int i = 0; i < WIN; i++) push(14'sd8, early);
    @(negedge clk);
    sampleValid = 1'b0;
    chk("R10 fresh window result", 32'(result), 32'h808);
    chk("R10 R7 over on fresh window", 32'(overTemp), 1);
    chk("R10 R8 under equal limit", 32'(underTemp), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule